// File: doc/BRIEF.md
# Trap and Return Status Controller

This block holds the live status flags of a processor core (stack mode, interrupt enable and carry), a shadow copy of each of them, and a saved return address. It acts on one-cycle command strobes from the decode stage.

A trap strobe saves the live flags into the shadows. It keeps stack mode, clears interrupt enable and carry, records the address of the instruction after the trap, and issues a redirect to a handler slot picked by the 4-bit trap number. A return strobe copies the shadows back into the live flags and redirects to the saved address, rounded down to a word boundary. A set-status strobe ORs an 8-bit immediate into the flags, so it can set flags but never clear them.

A separate flag tracks the bus lock held between a locked load and the matching unlocking store.

Top module: `trap_status_ctrl`

## Requirements
- R1: After reset, stack mode, interrupt enable, carry, the lock flag and the redirect valid output are all 0.
- R2: On a trap, the shadow flags take the values that stack mode, interrupt enable and carry held just before the trap. A later return makes these values visible.
- R3: On a trap, stack mode keeps its value and interrupt enable and carry become 0 on the next clock edge.
- R4: The clock edge after a trap strobe raises the redirect valid output for one cycle, with a redirect address of VEC_BASE + 4*n, where n is the 4-bit trap number.
- R5: On a trap, the saved return address becomes the current PC input plus 4.
- R6: On a return (without a trap in the same cycle), stack mode, interrupt enable and carry are reloaded from the shadow flags on the next edge.
- R7: The edge after a return raises the redirect valid output for one cycle, with the saved return address and its bits [1:0] forced to 0.
- R8: When trap and return strobes arrive in the same cycle, only the trap takes effect and the return is ignored.
- R9: Set-status ORs immediate bit 7 into stack mode, bit 6 into interrupt enable and bit 0 into carry. It never clears a flag. Immediate bits 1 to 5 have no effect. The strobe is ignored in a cycle that also carries a trap or a return.
- R10: A lock strobe sets the lock flag and an unlock strobe clears it. When both arrive in the same cycle, the flag is cleared.
- R11: The redirect valid output is low in every cycle that does not follow a trap or return strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Trap command strobe |
| trap_num_i | input | 4 | Trap number selecting the handler slot |
| ret_i | input | 1 | Return-from-exception strobe |
| setst_i | input | 1 | Set-status strobe |
| setst_imm_i | input | 8 | Immediate ORed into the status flags |
| lock_i | input | 1 | Bus lock set strobe |
| unlock_i | input | 1 | Bus lock clear strobe |
| cur_pc_i | input | 32 | Address of the instruction carrying the strobe |
| stk_mode_o | output | 1 | Live stack mode flag |
| int_en_o | output | 1 | Live interrupt enable flag |
| carry_o | output | 1 | Live carry flag |
| redir_valid_o | output | 1 | Redirect request, one cycle |
| redir_pc_o | output | 32 | Redirect target address |
| lock_o | output | 1 | Bus lock flag |

## Verification
Trap and return can land in the same cycle, and either of them can coincide with a set-status. The same is true of lock and unlock. The bench drives these pairs together on purpose, with flag and shadow patterns that differ, so that the command that wins can be told apart from the one that loses. A behavioural reference model that applies the stated priorities is compared against every output on every clock. A wrong winner therefore shows up as a flag or redirect mismatch in the cycle right after the collision, or at the next return.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_TRAP = 2'd1,
      EV_RET  = 2'd2,
      EV_SET  = 2'd3
   } status_ev_e;

   localparam int FLAG_CNT = 3;
   localparam int CY_IDX   = 0;
   localparam int IE_IDX   = 1;
   localparam int SM_IDX   = 2;

   // immediate bit that feeds each status flag
   function automatic int imm_bit_of(input int flag_idx);
      case (flag_idx)
         SM_IDX:  return 7;
         IE_IDX:  return 6;
         default: return 0;
      endcase
   endfunction

   // trap beats return, return beats set-status
   function automatic status_ev_e pick_event(input logic trap, input logic ret,
                                             input logic setst);
      if (trap)       return EV_TRAP;
      else if (ret)   return EV_RET;
      else if (setst) return EV_SET;
      else            return EV_NONE;
   endfunction

endpackage

// File: rtl/status_flags.sv
module status_flags
   import trap_ctrl_pkg::*;
#(
   parameter int IMM_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  status_ev_e          ev_i,
   input  logic [IMM_W-1:0]    imm_i,
   output logic [FLAG_CNT-1:0] live_o,
   output logic [FLAG_CNT-1:0] shadow_o
);

   if (IMM_W < 8) begin : g_bad_imm
      $error("status_flags: IMM_W must be at least 8");
   end

   for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
      localparam int  IMM_POS = imm_bit_of(i);
      localparam bit  KEEP_ON_TRAP = (i == SM_IDX);
      logic live_q;
      logic shadow_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q   <= 1'b0;
            shadow_q <= 1'b0;
         end else begin
            case (ev_i)
               EV_TRAP: begin
                  shadow_q <= live_q;
                  live_q   <= KEEP_ON_TRAP ? live_q : 1'b0;
               end
               EV_RET:  live_q <= shadow_q;
               EV_SET:  live_q <= live_q | imm_i[IMM_POS];
               default: ;
            endcase
         end
      end

      assign live_o[i]   = live_q;
      assign shadow_o[i] = shadow_q;
   end

   // R3
   trap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_TRAP) |=> (!live_o[IE_IDX] && !live_o[CY_IDX] &&
                             live_o[SM_IDX] == $past(live_o[SM_IDX])));
   // R2
   trap_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_TRAP) |=> (shadow_o == $past(live_o)));
   // R6
   ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_RET) |=> (live_o == $past(shadow_o)));
   // R9
   set_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_SET) |=> ((live_o & $past(live_o)) == $past(live_o)));

endmodule

// File: rtl/pc_redirect.sv
module pc_redirect #(
   parameter int          ADDR_W      = 32,
   parameter int          NUM_W       = 4,
   parameter int unsigned VEC_BASE    = 'h100,
   parameter int          VEC_STRIDE  = 4,
   parameter int          INSTR_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_trap_i,
   input  logic              do_ret_i,
   input  logic [NUM_W-1:0]  num_i,
   input  logic [ADDR_W-1:0] cur_pc_i,
   output logic              redir_valid_o,
   output logic [ADDR_W-1:0] redir_pc_o
);

   localparam int          STRIDE_SH  = $clog2(VEC_STRIDE);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(INSTR_BYTES - 1);
   localparam logic [ADDR_W-1:0] BASE_ADDR  = ADDR_W'(VEC_BASE);
   localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(INSTR_BYTES);

   if ((1 << STRIDE_SH) != VEC_STRIDE) begin : g_bad_stride
      $error("pc_redirect: VEC_STRIDE must be a power of two");
   end
   if ((INSTR_BYTES & (INSTR_BYTES - 1)) != 0) begin : g_bad_step
      $error("pc_redirect: INSTR_BYTES must be a power of two");
   end
   if (NUM_W + STRIDE_SH > ADDR_W) begin : g_bad_num
      $error("pc_redirect: vector offset wider than address");
   end

   logic [ADDR_W-1:0] bpc_q;
   logic [ADDR_W-1:0] slot_addr;

   assign slot_addr = BASE_ADDR + (ADDR_W'(num_i) << STRIDE_SH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bpc_q         <= '0;
         redir_valid_o <= 1'b0;
         redir_pc_o    <= '0;
      end else begin
         redir_valid_o <= do_trap_i | do_ret_i;
         if (do_trap_i) begin
            bpc_q      <= cur_pc_i + STEP;
            redir_pc_o <= slot_addr;
         end else if (do_ret_i) begin
            redir_pc_o <= bpc_q & ~ALIGN_MASK;
         end
      end
   end

   // R7
   ret_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_ret_i && !do_trap_i) |=> (redir_valid_o && (redir_pc_o & ALIGN_MASK) == '0));
   // R5
   trap_bpc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_trap_i |=> (bpc_q == $past(cur_pc_i) + STEP));
   // R11
   idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!do_trap_i && !do_ret_i) |=> !redir_valid_o);

endmodule

// File: rtl/bus_lock_flag.sv
module bus_lock_flag #(
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic lock_o
);

   logic nxt;

   if (CLEAR_WINS) begin : g_clr_first
      always_comb begin
         nxt = lock_o;
         if (clr_i)      nxt = 1'b0;
         else if (set_i) nxt = 1'b1;
      end
   end else begin : g_set_first
      always_comb begin
         nxt = lock_o;
         if (set_i)      nxt = 1'b1;
         else if (clr_i) nxt = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lock_o <= 1'b0;
      else        lock_o <= nxt;
   end

   // R10
   unlock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && CLEAR_WINS) |=> !lock_o);
   // R10
   lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> lock_o);

endmodule

// File: rtl/trap_status_ctrl.sv
module trap_status_ctrl
   import trap_ctrl_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          NUM_W       = 4,
   parameter int          IMM_W       = 8,
   parameter int unsigned VEC_BASE    = 'h100,
   parameter int          VEC_STRIDE  = 4,
   parameter int          INSTR_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_i,
   input  logic [NUM_W-1:0]  trap_num_i,
   input  logic              ret_i,
   input  logic              setst_i,
   input  logic [IMM_W-1:0]  setst_imm_i,
   input  logic              lock_i,
   input  logic              unlock_i,
   input  logic [ADDR_W-1:0] cur_pc_i,
   output logic              stk_mode_o,
   output logic              int_en_o,
   output logic              carry_o,
   output logic              redir_valid_o,
   output logic [ADDR_W-1:0] redir_pc_o,
   output logic              lock_o
);

   status_ev_e          ev;
   logic [FLAG_CNT-1:0] live;
   logic [FLAG_CNT-1:0] shadow;

   assign ev = pick_event(trap_i, ret_i, setst_i);

   status_flags #(.IMM_W(IMM_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_i     (ev),
      .imm_i    (setst_imm_i),
      .live_o   (live),
      .shadow_o (shadow)
   );

   pc_redirect #(
      .ADDR_W      (ADDR_W),
      .NUM_W       (NUM_W),
      .VEC_BASE    (VEC_BASE),
      .VEC_STRIDE  (VEC_STRIDE),
      .INSTR_BYTES (INSTR_BYTES)
   ) u_redir (
      .clk           (clk),
      .rst_n         (rst_n),
      .do_trap_i     (ev == EV_TRAP),
      .do_ret_i      (ev == EV_RET),
      .num_i         (trap_num_i),
      .cur_pc_i      (cur_pc_i),
      .redir_valid_o (redir_valid_o),
      .redir_pc_o    (redir_pc_o)
   );

   bus_lock_flag #(.CLEAR_WINS(1'b1)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (lock_i),
      .clr_i  (unlock_i),
      .lock_o (lock_o)
   );

   assign stk_mode_o = live[SM_IDX];
   assign int_en_o   = live[IE_IDX];
   assign carry_o    = live[CY_IDX];

   // R8
   trap_over_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_i && ret_i) |=> (!int_en_o && !carry_o));
   // R4
   trap_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> (redir_valid_o &&
                  redir_pc_o == ADDR_W'(VEC_BASE) + ADDR_W'($past(trap_num_i)) * ADDR_W'(VEC_STRIDE)));

   // R1
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_state_chk: assert ($past(rst_n) || (!lock_o && !redir_valid_o &&
                                live == '0) || $isunknown(live) || $isunknown(lock_o));
      end
   end

endmodule

// File: tb/trap_status_ctrl_tb_top.sv
module trap_status_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int BASE = 'h100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_i = 1'b0;
   logic [3:0]  trap_num_i = '0;
   logic        ret_i = 1'b0;
   logic        setst_i = 1'b0;
   logic [7:0]  setst_imm_i = '0;
   logic        lock_i = 1'b0;
   logic        unlock_i = 1'b0;
   logic [31:0] cur_pc_i = '0;
   logic        stk_mode_o, int_en_o, carry_o, redir_valid_o, lock_o;
   logic [31:0] redir_pc_o;

   int checks = 0;
   int errors = 0;

   // reference model state
   bit          m_sm, m_ie, m_cy, m_bsm, m_bie, m_bcy, m_lock, m_rv;
   logic [31:0] m_bpc, m_rpc;

   always #(CLK_PERIOD/2) clk = ~clk;

   trap_status_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .trap_num_i(trap_num_i),
      .ret_i(ret_i), .setst_i(setst_i), .setst_imm_i(setst_imm_i),
      .lock_i(lock_i), .unlock_i(unlock_i), .cur_pc_i(cur_pc_i),
      .stk_mode_o(stk_mode_o), .int_en_o(int_en_o), .carry_o(carry_o),
      .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o), .lock_o(lock_o)
   );

   task automatic compare(input string tag);
      logic [36:0] act, exp;
      act = {stk_mode_o, int_en_o, carry_o, lock_o, redir_valid_o, redir_pc_o};
      exp = {m_sm, m_ie, m_cy, m_lock, m_rv, m_rpc};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act sm/ie/cy/lk/rv/pc=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_sm = 0; m_ie = 0; m_cy = 0; m_bsm = 0; m_bie = 0; m_bcy = 0;
      m_lock = 0; m_rv = 0; m_bpc = '0; m_rpc = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      compare("R1");
   endtask

   task automatic step(input string tag, input bit t, input logic [3:0] n,
                       input bit r, input bit s, input logic [7:0] im,
                       input bit lk, input bit ul, input logic [31:0] pc);
      trap_i = t; trap_num_i = n; ret_i = r; setst_i = s; setst_imm_i = im;
      lock_i = lk; unlock_i = ul; cur_pc_i = pc;
      // model next state
      m_rv = t || r;
      if (t) begin
         m_bsm = m_sm; m_bie = m_ie; m_bcy = m_cy;
         m_ie = 0; m_cy = 0;
         m_bpc = pc + 32'd4;
         m_rpc = BASE + 4 * int'(n);
      end else if (r) begin
         m_sm = m_bsm; m_ie = m_bie; m_cy = m_bcy;
         m_rpc = {m_bpc[31:2], 2'b00};
      end else if (s) begin
         m_sm = m_sm | im[7]; m_ie = m_ie | im[6]; m_cy = m_cy | im[0];
      end
      if (ul)      m_lock = 0;
      else if (lk) m_lock = 1;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input string tag);
      step(tag, 0, 4'h0, 0, 0, 8'h00, 0, 0, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      idle("R11");
      // R9: middle immediate bits do nothing
      step("R9", 0, 4'h0, 0, 1, 8'h3E, 0, 0, 32'h0);
      step("R9", 0, 4'h0, 0, 1, 8'h01, 0, 0, 32'h0);
      step("R9", 0, 4'h0, 0, 1, 8'hC0, 0, 0, 32'h0);
      step("R9", 0, 4'h0, 0, 1, 8'h00, 0, 0, 32'h0);
      // R3 R4 R5: trap with unaligned pc
      step("R3", 1, 4'h5, 0, 0, 8'h00, 0, 0, 32'h0000_1003);
      idle("R11");
      step("R9", 0, 4'h0, 0, 1, 8'h01, 0, 0, 32'h0);
      // R6 R7 R2: return restores 1,1,1 and aligned 0x1004
      step("R6", 0, 4'h0, 1, 0, 8'h00, 0, 0, 32'h0);
      idle("R11");

      // second pattern: only IE set before trap
      do_reset();
      step("R9", 0, 4'h0, 0, 1, 8'h40, 0, 0, 32'h0);
      step("R4", 1, 4'hF, 0, 0, 8'h00, 0, 0, 32'h0000_2000);
      step("R9", 0, 4'h0, 0, 1, 8'h81, 0, 0, 32'h0);
      step("R2", 0, 4'h0, 1, 0, 8'h00, 0, 0, 32'h0);
      idle("R7");

      // R8: trap and return together; trap wins
      step("R9", 0, 4'h0, 0, 1, 8'h81, 0, 0, 32'h0);
      step("R8", 1, 4'h3, 1, 0, 8'h00, 0, 0, 32'h0000_3002);
      step("R8", 0, 4'h0, 1, 0, 8'h00, 0, 0, 32'h0);
      // trap with set-status together: set ignored
      step("R9", 1, 4'h0, 0, 1, 8'hFF, 0, 0, 32'h0000_4000);
      // return with set-status together: set ignored
      step("R9", 0, 4'h0, 1, 1, 8'hFF, 0, 0, 32'h0);
      // nested traps overwrite the shadows
      step("R2", 1, 4'h1, 0, 0, 8'h00, 0, 0, 32'h0000_5000);
      step("R2", 1, 4'h2, 0, 0, 8'h00, 0, 0, 32'h0000_6001);
      step("R7", 0, 4'h0, 1, 0, 8'h00, 0, 0, 32'h0);
      step("R5", 1, 4'h7, 0, 0, 8'h00, 0, 0, 32'hFFFF_FFFE);
      step("R5", 0, 4'h0, 1, 0, 8'h00, 0, 0, 32'h0);

      // R10 lock handling
      step("R10", 0, 4'h0, 0, 0, 8'h00, 1, 0, 32'h0);
      idle("R10");
      step("R10", 0, 4'h0, 0, 0, 8'h00, 0, 1, 32'h0);
      step("R10", 0, 4'h0, 0, 0, 8'h00, 1, 0, 32'h0);
      step("R10", 0, 4'h0, 0, 0, 8'h00, 1, 1, 32'h0);
      step("R10", 0, 4'h0, 0, 0, 8'h00, 0, 1, 32'h0);
      step("R10", 1, 4'h9, 0, 0, 8'h00, 1, 0, 32'h0000_0100);
      do_reset();
      idle("R1");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule